// File: doc/BRIEF.md
# Packet to Cell Transmit Segmenter

The segmenter takes transmit descriptors from a pending queue and cuts each packet into cells of at most 64 bytes. It issues one cell request at a time to a downstream copy engine. A descriptor arrives as a handle plus three words: the buffer address, the packet length in bytes and the destination channel. A handle of zero means the queue had no work. The block consumes such an entry and keeps polling.

For each cell the block first asks a credit tracker for ring space. Once space is granted, it presents one request. The request carries a ring slot index that counts modulo 128, the source byte address inside the buffer and a packed control word. The control word holds the cell size, the start and end flags and the channel.

After the end cell of a packet is accepted, the buffer handle is offered on a completion queue, and the block waits there until the queue takes it. A descriptor with a nonzero handle and a length of zero is a fault. The block raises a sticky error and stops until it is reset.

Top module: `cell_segmenter`

## Requirements
- R1: A descriptor is accepted only while `desc_ready` is high, and `desc_ready` is high only when the block is idle. The handle, address, length and channel of that descriptor are captured in the same cycle.
- R2: An accepted descriptor whose handle is zero starts no packet. The block stays idle with `desc_ready` high, and no space request or cell follows.
- R3: Control bit 9 (the start flag) is set only on the cell whose byte offset within the packet is zero.
- R4: The cell size is the remaining length (length minus offset) when that value is 64 or less, and control bit 8 (the end flag) is then set. Otherwise the size is 64 and bit 8 is clear.
- R5: Each accepted cell advances the byte offset by its size and advances `cell_slot` by one modulo 128. `cell_slot` is 0 after reset.
- R6: Control word layout: bits 7:0 hold the channel, bits 9:8 hold {start, end}, bits 31:24 hold the cell size in bytes, and all other bits are zero.
- R7: `done_valid` rises only in the cycle after an end cell is accepted. It carries that packet's handle and stays high with the handle unchanged until `done_ready` is high.
- R8: `cell_src` equals the buffer address plus the byte offset. For an 8-byte-aligned buffer it is a multiple of 8.
- R9: Accepting a descriptor with a nonzero handle and zero length sets `err_zero_len`. The flag stays set until reset, and from then on `desc_ready`, `space_req`, `cell_valid` and `done_valid` all stay low.
- R10: Before each cell the block raises `space_req`. It presents exactly one cell request after the cycle in which `space_gnt` is high together with `space_req`. A grant seen at any other time has no effect.
- R11: During and right after reset, `desc_ready` is high and `space_req`, `cell_valid`, `done_valid` and `err_zero_len` are low.
- R12: While `cell_valid` is high and `cell_ready` is low, the request and all its fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| desc_valid | input | 1 | Pending-queue entry present |
| desc_ready | output | 1 | Block idle and taking an entry |
| desc_handle | input | 32 | Buffer handle, zero means no work |
| desc_addr | input | 32 | Buffer byte address |
| desc_len | input | 32 | Packet length in bytes |
| desc_chan | input | 8 | Destination channel |
| space_req | output | 1 | Asking for one ring slot of space |
| space_gnt | input | 1 | Space granted for one cell |
| cell_valid | output | 1 | Cell request present |
| cell_ready | input | 1 | Cell request taken |
| cell_slot | output | 7 | Ring slot index |
| cell_src | output | 32 | Source byte address of the cell |
| cell_ctrl | output | 32 | Packed size, start/end flags and channel |
| done_valid | output | 1 | Completed handle present |
| done_ready | input | 1 | Completion queue has room |
| done_handle | output | 32 | Handle of the finished packet |
| err_zero_len | output | 1 | Sticky zero-length fault |

## Verification
The alignment check on `cell_src` relies on every descriptor address being a multiple of 8. The stimulus masks the low three address bits of every nonzero-handle descriptor, so this holds. The hold-steady checks assume that downstream ready signals may toggle freely, and the bench drives `cell_ready`, `done_ready` and `space_gnt` at random in every cycle, including cycles where they are ignored. The zero-length fault is sent only as the final descriptor, so the halted state is observed last and for many cycles.

// File: rtl/cell_segmenter.sv
module cell_segmenter #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 32,
  parameter int HDL_W      = 32,
  parameter int CH_W       = 8,
  parameter int SLOTS      = 128,
  parameter int CELL_BYTES = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      desc_valid,
  output logic                      desc_ready,
  input  logic [HDL_W-1:0]          desc_handle,
  input  logic [ADDR_W-1:0]         desc_addr,
  input  logic [LEN_W-1:0]          desc_len,
  input  logic [CH_W-1:0]           desc_chan,
  output logic                      space_req,
  input  logic                      space_gnt,
  output logic                      cell_valid,
  input  logic                      cell_ready,
  output logic [$clog2(SLOTS)-1:0]  cell_slot,
  output logic [ADDR_W-1:0]         cell_src,
  output logic [31:0]               cell_ctrl,
  output logic                      done_valid,
  input  logic                      done_ready,
  output logic [HDL_W-1:0]          done_handle,
  output logic                      err_zero_len
);

  localparam int SLOT_W = $clog2(SLOTS);
  localparam int SZ_W   = $clog2(CELL_BYTES) + 1;
  localparam logic [SZ_W-1:0]  FULL_SZ  = SZ_W'(CELL_BYTES);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(CELL_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_CELL, S_DONE, S_HALT} state_t;

  state_t             st;
  logic [HDL_W-1:0]   hdl_q;
  logic [ADDR_W-1:0]  base_q;
  logic [LEN_W-1:0]   len_q;
  logic [LEN_W-1:0]   off_q;
  logic [CH_W-1:0]    chan_q;
  logic [SLOT_W-1:0]  slot_q;

  logic [LEN_W-1:0]   remain;
  logic               last;
  logic               first;
  logic [SZ_W-1:0]    size;

  assign remain = len_q - off_q;
  assign last   = remain <= FULL_LEN;
  assign first  = off_q == '0;
  assign size   = last ? remain[SZ_W-1:0] : FULL_SZ;

  assign desc_ready   = st == S_IDLE;
  assign space_req    = st == S_REQ;
  assign cell_valid   = st == S_CELL;
  assign done_valid   = st == S_DONE;
  assign err_zero_len = st == S_HALT;
  assign done_handle  = hdl_q;
  assign cell_slot    = slot_q;
  assign cell_src     = base_q + ADDR_W'(off_q);

  always_comb begin
    cell_ctrl            = '0;
    cell_ctrl[CH_W-1:0]  = chan_q;
    cell_ctrl[9:8]       = {first, last};
    cell_ctrl[31:24]     = 8'(size);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      hdl_q  <= '0;
      base_q <= '0;
      len_q  <= '0;
      off_q  <= '0;
      chan_q <= '0;
      slot_q <= '0;
    end else begin
      unique case (st)
        S_IDLE:
          if (desc_valid && desc_handle != '0) begin
            hdl_q  <= desc_handle;
            base_q <= desc_addr;
            len_q  <= desc_len;
            chan_q <= desc_chan;
            off_q  <= '0;
            st     <= (desc_len == '0) ? S_HALT : S_REQ;
          end
        S_REQ:
          if (space_gnt) st <= S_CELL;
        S_CELL:
          if (cell_ready) begin
            slot_q <= slot_q + 1'b1;
            off_q  <= off_q + LEN_W'(size);
            st     <= last ? S_DONE : S_REQ;
          end
        S_DONE:
          if (done_ready) st <= S_IDLE;
        S_HALT:
          st <= S_HALT;
        default:
          st <= S_HALT;
      endcase
    end
  end

  a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({desc_ready, space_req, cell_valid, done_valid, err_zero_len}));

  a_r2_null_handle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready && desc_valid && desc_handle == '0 |=> desc_ready);

  a_r3_start_on_first_cell: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid && cell_ready && !cell_ctrl[8] |=> !cell_valid || !cell_ctrl[9]);

  a_r4_size_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> cell_ctrl[31:24] != 8'd0 && cell_ctrl[31:24] <= 8'(CELL_BYTES)
                   && (cell_ctrl[8] || cell_ctrl[31:24] == 8'(CELL_BYTES)));

  a_r5_slot_steps: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid && cell_ready |=> cell_slot == SLOT_W'($past(cell_slot) + 1));

  a_r7_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_valid) |-> $past(cell_valid && cell_ready && cell_ctrl[8]));

  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_ready |=> done_valid && $stable(done_handle));

  a_r8_src_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> cell_src[2:0] == 3'b000);

  a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_zero_len |=> err_zero_len && !desc_ready);

  a_r10_cell_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cell_valid) |-> $past(space_req && space_gnt));

  a_r12_cell_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid && !cell_ready |=> cell_valid && $stable(cell_ctrl)
                                  && $stable(cell_src) && $stable(cell_slot));

endmodule

// File: tb/cell_segmenter_bench.sv
module cell_segmenter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n;
  logic        desc_valid, desc_ready;
  logic [31:0] desc_handle, desc_addr, desc_len;
  logic [7:0]  desc_chan;
  logic        space_req, space_gnt;
  logic        cell_valid, cell_ready;
  logic [6:0]  cell_slot;
  logic [31:0] cell_src, cell_ctrl;
  logic        done_valid, done_ready;
  logic [31:0] done_handle;
  logic        err_zero_len;

  cell_segmenter u_cell_segmenter (
    .clk(clk), .rst_n(rst_n),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_handle(desc_handle), .desc_addr(desc_addr),
    .desc_len(desc_len), .desc_chan(desc_chan),
    .space_req(space_req), .space_gnt(space_gnt),
    .cell_valid(cell_valid), .cell_ready(cell_ready),
    .cell_slot(cell_slot), .cell_src(cell_src), .cell_ctrl(cell_ctrl),
    .done_valid(done_valid), .done_ready(done_ready),
    .done_handle(done_handle), .err_zero_len(err_zero_len)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int fails   = 0;

  int unsigned q_hdl[$], q_addr[$], q_len[$], q_chan[$];

  int          ph = 0;
  int unsigned m_hdl, m_addr, m_len, m_chan, m_off;
  int          m_slot = 0;
  int          halt_cycles = 0;
  int          starts_seen = 0;
  int          wraps_seen  = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic push_desc(input int unsigned h, input int unsigned a,
                           input int unsigned l, input int unsigned c);
    q_hdl.push_back(h); q_addr.push_back(a & ~32'h7);
    q_len.push_back(l); q_chan.push_back(c & 8'hff);
  endtask

  task automatic final_report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    fails++;
    $display("FAIL watchdog expired");
    final_report();
    $finish;
  end

  initial begin
    int unsigned rem, sz, eop, sop, ectrl;
    push_desc(0, 0, 0, 0);
    push_desc(1, 32'h1000, 1, 3);
    push_desc(2, 32'h2008, 63, 4);
    push_desc(3, 32'h3010, 64, 5);
    push_desc(0, 0, 0, 0);
    push_desc(4, 32'h4018, 65, 6);
    push_desc(5, 32'h5000, 128, 7);
    push_desc(6, 32'h6040, 129, 8'hff);
    for (int i = 0; i < 60; i++) begin
      if (i % 9 == 4) push_desc(0, $urandom, $urandom, 0);
      push_desc(100 + i, $urandom, 1 + ($urandom % 300), $urandom);
    end
    push_desc(999, 32'h7000, 0, 9);

    rst_n = 0; desc_valid = 0; desc_handle = 0; desc_addr = 0;
    desc_len = 0; desc_chan = 0; space_gnt = 0; cell_ready = 0; done_ready = 0;
    repeat (3) @(negedge clk);
    check("R11 ready in reset", desc_ready, 1);
    check("R11 valids in reset", {space_req, cell_valid, done_valid, err_zero_len}, 0);
    check("R11 slot in reset", cell_slot, 0);
    rst_n = 1;

    while (!(ph == 4 && halt_cycles > 40)) begin
      @(negedge clk);
      check("R1 desc_ready", desc_ready, ph == 0);
      check("R10 space_req", space_req, ph == 1);
      check("R7 done_valid", done_valid, ph == 3);
      check("R9 err_zero_len", err_zero_len, ph == 4);
      check("R10 cell_valid", cell_valid, ph == 2);
      rem = m_len - m_off;
      eop = (rem <= 64) ? 1 : 0;
      sz  = eop ? rem : 64;
      sop = (m_off == 0) ? 1 : 0;
      ectrl = (sz << 24) | (sop << 9) | (eop << 8) | m_chan;
      if (ph == 2) begin
        check("R5 cell_slot", cell_slot, m_slot);
        check("R8 cell_src", cell_src, 32'(m_addr + m_off));
        check("R3 start flag", cell_ctrl[9], sop);
        check("R4 end flag", cell_ctrl[8], eop);
        check("R4 cell size", cell_ctrl[31:24], sz);
        check("R6 control word", cell_ctrl, ectrl);
      end
      if (ph == 3) check("R7 done_handle", done_handle, m_hdl);

      desc_valid = (q_hdl.size() > 0) && ($urandom % 3 != 0);
      if (desc_valid) begin
        desc_handle = q_hdl[0]; desc_addr = q_addr[0];
        desc_len = q_len[0]; desc_chan = 8'(q_chan[0]);
      end else begin
        desc_handle = $urandom; desc_addr = $urandom;
        desc_len = $urandom; desc_chan = 8'($urandom);
      end
      space_gnt  = ($urandom % 3) == 0;
      cell_ready = ($urandom % 2) == 0;
      done_ready = ($urandom % 3) != 0;

      case (ph)
        0: if (desc_valid) begin
             m_hdl = q_hdl.pop_front(); m_addr = q_addr.pop_front();
             m_len = q_len.pop_front(); m_chan = q_chan.pop_front();
             if (m_hdl != 0) begin
               m_off = 0;
               ph = (m_len == 0) ? 4 : 1;
               starts_seen++;
             end
           end
        1: if (space_gnt) ph = 2;
        2: if (cell_ready) begin
             m_slot = (m_slot + 1) % 128;
             if (m_slot == 0) wraps_seen++;
             m_off = m_off + sz;
             ph = eop ? 3 : 1;
           end
        3: if (done_ready) ph = 0;
        default: halt_cycles++;
      endcase
    end
    check("R5 slot index wrapped", wraps_seen > 0, 1);
    check("R2 null handles skipped", starts_seen, 67);
    final_report();
    $finish;
  end
endmodule